// File: doc/BRIEF.md
# Byte-Wide EEPROM Access Controller with Burst Loader

This block sits between a host register bus and an external byte-wide EEPROM. Software reaches the EEPROM through a handful of word registers. It loads an EEPROM address and a data byte, and then sets a request bit to read or write one byte. A separate start bit launches a burst that copies a run of consecutive EEPROM bytes into device memory through a byte write port with a 24-bit address.

The EEPROM side is a plain request/acknowledge handshake. The controller raises a request with an address, a write flag and a byte, and holds all of them steady until the device acknowledges. On a read, the device returns the byte together with the acknowledge. If no acknowledge arrives within a parameterised number of cycles, the access is dropped and a sticky flag records the event.

A burst resumes at the EEPROM address after the most recent access, or at address zero if there has been no access since reset. Each fetched byte goes to a memory address formed from a 9-bit base register above the low 15 bits of the EEPROM address. The top EEPROM address bit plays no part in that address.

Top module: `ee_access_ctl`

## Requirements
- R1: After reset, every register reads zero, `ee_req` is low and `mem_we` is low.
- R2: Writing the control register (index 0) with bit 1 set reads one EEPROM byte at the address register (index 1) into the data register (index 2). Control bit 1 reads 1 until that byte is loaded and 0 afterwards.
- R3: Writing the control register with bit 0 set performs one EEPROM write of data register bits [7:0] to the address register, with `ee_we` high. Control bit 0 clears when the write completes.
- R4: Writing the burst register (index 3) with bit 0 set reads BURST_LEN consecutive EEPROM bytes and writes each to device memory. Burst bit 0 reads 1 until the last byte is written.
- R5: A burst starts at EEPROM address 0 when no access has run since reset, and otherwise at one past the last EEPROM address accessed (wrapping at 16 bits).
- R6: A byte fetched from EEPROM address A appears on `mem_wdata` with `mem_addr` = {base register (index 4) bits [8:0], A[14:0]}. A[15] is ignored, so the low field wraps from 0x7FFF to 0.
- R7: Control bit 2 reads 1 while an access is in progress. Register writes made during that time change nothing.
- R8: If `ee_ack` stays low for TIMEOUT_CYC cycles of request, the access is abandoned. Control bit 3 becomes 1 and stays 1 until reset. The request bit of that access clears, and the data register keeps its old value.
- R9: Pending requests launch only in a cycle with no register write. The order is read first, then write, then burst, so a single access set together with a burst start runs before it.
- R10: While `ee_req` is high without acknowledge or timeout, `ee_addr`, `ee_we` and `ee_wdata` stay stable. Each acknowledge completes exactly one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 control, 1 address, 2 data, 3 burst, 4 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_idx |
| ee_req | output | 1 | EEPROM transfer request |
| ee_we | output | 1 | 1 for a write transfer, 0 for a read |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | Transfer acknowledge from the EEPROM |
| ee_rdata | input | 8 | Byte read, valid with ee_ack |
| mem_we | output | 1 | Device memory byte write strobe |
| mem_addr | output | 24 | Device memory byte address |
| mem_wdata | output | 8 | Device memory write byte |

## Verification
On every cycle, the assertions check four things: the EEPROM request holds steady until it is acknowledged or times out, memory writes only follow an acknowledged transfer into the current base window, register writes are locked out during an access, and the timeout flag only rises after a wait with no acknowledge. Some behaviour only the bench scenarios can show. This covers the burst start address after reset, after single accesses and after earlier bursts, and the wrap of the low destination field across EEPROM address 0x7FFF. It also covers the order in which a read, a write and a burst requested together are served, and the exact length of a timed-out request.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_BURST = 2'd2
    } ee_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } ee_state_e;

    localparam logic [2:0] RI_CTRL  = 3'd0;
    localparam logic [2:0] RI_ADDR  = 3'd1;
    localparam logic [2:0] RI_DATA  = 3'd2;
    localparam logic [2:0] RI_BURST = 3'd3;
    localparam logic [2:0] RI_BASE  = 3'd4;

    localparam int CB_WR   = 0;
    localparam int CB_RD   = 1;
    localparam int CB_BUSY = 2;
    localparam int CB_TMO  = 3;

    typedef struct packed {
        logic rd;
        logic wr;
        logic burst;
    } ee_pend_t;

    typedef struct packed {
        logic clr_rd;
        logic clr_wr;
        logic clr_burst;
        logic load_rd;
        logic set_tmo;
    } ee_upd_t;

    function automatic ee_op_e pick_op(input ee_pend_t p);
        if (p.rd)      return OP_READ;
        else if (p.wr) return OP_WRITE;
        else           return OP_BURST;
    endfunction

endpackage

// File: rtl/ee_ack_timer.sv
module ee_ack_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !req || ack) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = req && !ack && (cnt == LAST);

endmodule

// File: rtl/ee_ctl_regs.sv
module ee_ctl_regs import ee_pkg::*; #(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  ee_upd_t           upd,
    input  logic [7:0]        rd_byte,
    output ee_pend_t          pend,
    output logic [EE_AW-1:0]  addr_q,
    output logic [7:0]        data_q,
    output logic [BASE_W-1:0] base_q,
    output logic              tmo
);
    logic accept;
    logic unused_wdata;

    assign accept       = reg_wr && !busy;
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
            tmo    <= 1'b0;
        end else begin
            if (accept) begin
                case (reg_idx)
                    RI_CTRL: begin
                        if (reg_wdata[CB_RD]) pend.rd <= 1'b1;
                        if (reg_wdata[CB_WR]) pend.wr <= 1'b1;
                    end
                    RI_ADDR:  addr_q <= reg_wdata[EE_AW-1:0];
                    RI_DATA:  data_q <= reg_wdata[7:0];
                    RI_BURST: if (reg_wdata[0]) pend.burst <= 1'b1;
                    RI_BASE:  base_q <= reg_wdata[BASE_W-1:0];
                    default: ;
                endcase
            end
            if (upd.clr_rd)    pend.rd    <= 1'b0;
            if (upd.clr_wr)    pend.wr    <= 1'b0;
            if (upd.clr_burst) pend.burst <= 1'b0;
            if (upd.load_rd)   data_q     <= rd_byte;
            if (upd.set_tmo)   tmo        <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            RI_CTRL: begin
                reg_rdata[CB_WR]   = pend.wr;
                reg_rdata[CB_RD]   = pend.rd;
                reg_rdata[CB_BUSY] = busy;
                reg_rdata[CB_TMO]  = tmo;
            end
            RI_ADDR:  reg_rdata = 32'(addr_q);
            RI_DATA:  reg_rdata = 32'(data_q);
            RI_BURST: reg_rdata = 32'(pend.burst);
            RI_BASE:  reg_rdata = 32'(base_q);
            default:  reg_rdata = '0;
        endcase
    end

    AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr) |=> ($stable(addr_q) && $stable(base_q))) // R7
        else $error("register changed during access");

    AST_RD_CLEARED_BY_HW: assert property (@(posedge clk) disable iff (rst)
        $fell(pend.rd) |-> $past(busy)) // R2
        else $error("read request dropped without an access");

endmodule

// File: rtl/ee_seq.sv
module ee_seq import ee_pkg::*; #(
    parameter int EE_AW     = 16,
    parameter int BASE_W    = 9,
    parameter int DEST_W    = 24,
    parameter int BURST_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  ee_pend_t          pend,
    input  logic [EE_AW-1:0]  addr_q,
    input  logic [7:0]        data_q,
    input  logic [BASE_W-1:0] base_q,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    input  logic              expire,
    output logic              busy,
    output ee_upd_t           upd,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    output logic              mem_we,
    output logic [DEST_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int LOW_W = DEST_W - BASE_W;
    localparam int BCW   = $clog2(BURST_LEN + 1);
    localparam logic [BCW-1:0] LAST_IDX = BCW'(BURST_LEN - 1);

    ee_state_e        st;
    ee_op_e           op;
    ee_op_e           nxt_op;
    logic [EE_AW-1:0] cur_addr;
    logic [EE_AW-1:0] last_addr;
    logic [EE_AW-1:0] start_addr;
    logic             last_valid;
    logic [BCW-1:0]   bcnt;
    logic             any_pend;
    logic             done_byte;
    logic             quit;
    logic             burst_end;

    assign any_pend  = pend.rd || pend.wr || pend.burst;
    assign nxt_op    = pick_op(pend);
    assign done_byte = (st == ST_REQ) && ee_ack;
    assign quit      = (st == ST_REQ) && !ee_ack && expire;
    assign burst_end = (op == OP_BURST) && (bcnt == LAST_IDX);

    always_comb begin
        if (nxt_op == OP_BURST) begin
            start_addr = last_valid ? last_addr + 1'b1 : '0;
        end else begin
            start_addr = addr_q;
        end
    end

    always_comb begin
        upd = '0;
        if (done_byte) begin
            case (op)
                OP_READ:  begin upd.clr_rd = 1'b1; upd.load_rd = 1'b1; end
                OP_WRITE: upd.clr_wr = 1'b1;
                default:  upd.clr_burst = burst_end;
            endcase
        end else if (quit) begin
            upd.set_tmo = 1'b1;
            case (op)
                OP_READ:  upd.clr_rd = 1'b1;
                OP_WRITE: upd.clr_wr = 1'b1;
                default:  upd.clr_burst = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            op         <= OP_READ;
            cur_addr   <= '0;
            last_addr  <= '0;
            last_valid <= 1'b0;
            bcnt       <= '0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            mem_we <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (any_pend && !reg_wr) begin
                        op         <= nxt_op;
                        cur_addr   <= start_addr;
                        last_addr  <= start_addr;
                        last_valid <= 1'b1;
                        bcnt       <= '0;
                        st         <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (ee_ack) begin
                        if (op == OP_BURST) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= {base_q, cur_addr[LOW_W-1:0]};
                            mem_wdata <= ee_rdata;
                            if (burst_end) begin
                                st <= ST_IDLE;
                            end else begin
                                bcnt      <= bcnt + 1'b1;
                                cur_addr  <= cur_addr + 1'b1;
                                last_addr <= cur_addr + 1'b1;
                                st        <= ST_GAP;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (expire) begin
                        st <= ST_IDLE;
                    end
                end
                ST_GAP:  st <= ST_REQ;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign ee_req   = (st == ST_REQ);
    assign ee_we    = ee_req && (op == OP_WRITE);
    assign ee_addr  = cur_addr;
    assign ee_wdata = data_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ee_req && !ee_ack && !expire) |=>
            (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata))) // R10
        else $error("request changed before acknowledge");

    AST_MEM_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(ee_ack && ee_req)) // R6
        else $error("memory write without acknowledged fetch");

    AST_MEM_IN_BASE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[DEST_W-1:LOW_W] == $past(base_q))) // R6
        else $error("memory write outside base window");

    AST_WE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (ee_req && ee_we) |-> pend.wr) // R3
        else $error("write transfer without write request");

endmodule

// File: rtl/ee_access_ctl.sv
module ee_access_ctl import ee_pkg::*; #(
    parameter int EE_AW       = 16,
    parameter int BASE_W      = 9,
    parameter int DEST_W      = 24,
    parameter int BURST_LEN   = 64,
    parameter int TIMEOUT_CYC = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    output logic              mem_we,
    output logic [DEST_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    ee_pend_t          pend;
    ee_upd_t           upd;
    logic [EE_AW-1:0]  addr_q;
    logic [7:0]        data_q;
    logic [BASE_W-1:0] base_q;
    logic              tmo;
    logic              busy;
    logic              expire;

    ee_ctl_regs #(.EE_AW(EE_AW), .BASE_W(BASE_W)) i_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .upd(upd), .rd_byte(ee_rdata),
        .pend(pend), .addr_q(addr_q), .data_q(data_q), .base_q(base_q), .tmo(tmo)
    );

    ee_seq #(.EE_AW(EE_AW), .BASE_W(BASE_W), .DEST_W(DEST_W), .BURST_LEN(BURST_LEN)) i_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr),
        .pend(pend), .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata), .expire(expire),
        .busy(busy), .upd(upd),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    ee_ack_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk(clk), .rst(rst), .req(ee_req), .ack(ee_ack), .expire(expire)
    );

    AST_TMO_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo) |-> ($past(ee_req) && !$past(ee_ack))) // R8
        else $error("timeout flag without an unanswered request");

    AST_NO_LAUNCH_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(reg_wr)) // R9
        else $error("access launched during a register write");

endmodule

// File: tb/test_ee_access_ctl.sv
`timescale 1ns/1ps
module test_ee_access_ctl;
    localparam int BL  = 64;
    localparam int TMO = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int mute = 0;
    int fixed_lat = 0;

    ee_access_ctl #(.BURST_LEN(BL), .TIMEOUT_CYC(TMO)) i_ee_access_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // EEPROM model and monitors
    logic [7:0]  model [0:1023];
    logic [15:0] log_addr [0:511];
    logic        log_we   [0:511];
    logic [7:0]  log_data [0:511];
    logic [23:0] cap_addr [0:511];
    logic [7:0]  cap_data [0:511];
    int log_n = 0, cap_n = 0;
    int model_ready = 0;
    int waited = 0, lat = 0, acked = 0;
    int run = 0, last_run = 0, viol = 0;
    logic        prev_req = 1'b0;
    logic [15:0] prev_addr = '0;

    always @(negedge clk) begin
        if (model_ready == 0) begin
            for (int k = 0; k < 1024; k++) model[k] = init_byte(k);
            model_ready = 1;
        end
        ee_ack = 1'b0;
        if (ee_req && prev_req && !acked && ee_addr !== prev_addr) viol++;
        prev_req  = ee_req;
        prev_addr = ee_addr;
        if (ee_req) run++;
        else if (run > 0) begin last_run = run; run = 0; end
        if (!ee_req) begin
            waited = 0;
            acked  = 0;
            lat    = fixed_lat + int'($urandom_range(0, 3));
        end else if (acked == 0 && mute == 0) begin
            if (waited >= lat) begin
                ee_ack   = 1'b1;
                ee_rdata = model[ee_addr[9:0]];
                if (ee_we) model[ee_addr[9:0]] = ee_wdata;
                if (log_n < 512) begin
                    log_addr[log_n] = ee_addr;
                    log_we[log_n]   = ee_we;
                    log_data[log_n] = ee_wdata;
                    log_n++;
                end
                acked = 1;
            end else begin
                waited++;
            end
        end
        if (mem_we && cap_n < 512) begin
            cap_addr[cap_n] = mem_addr;
            cap_data[cap_n] = mem_wdata;
            cap_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_two(input logic [2:0] i0, input logic [31:0] d0,
                          input logic [2:0] i1, input logic [31:0] d1);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i0; reg_wdata = d0;
        @(negedge clk);
        reg_idx = i1; reg_wdata = d1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c, b;
        for (int k = 0; k < 20000; k++) begin
            rd_reg(3'd0, c);
            rd_reg(3'd3, b);
            if (c[2:0] == 3'b000 && b[0] == 1'b0) return;
        end
        chk("wait_idle", 32'd1, 32'd0);
    endtask

    task automatic single_read(input logic [15:0] a, output logic [31:0] d);
        wr_reg(3'd1, 32'(a));
        wr_reg(3'd0, 32'h2);
        wait_idle();
        rd_reg(3'd2, d);
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] a;
        logic [7:0]  b8;
        int lb, cb;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int r = 0; r < 5; r++) begin
            rd_reg(3'(r), v);
            chk("R1 register after reset", v, 32'd0);
        end
        chk("R1 ee_req after reset", 32'(ee_req), 32'd0);
        chk("R1 mem_we after reset", 32'(mem_we), 32'd0);

        // R4 R5 R6: first burst starts at EEPROM address 0
        wr_reg(3'd4, 32'h1A5);
        cb = cap_n;
        wr_reg(3'd3, 32'h1);
        rd_reg(3'd3, v);
        chk("R4 burst bit set while running", v, 32'd1);
        wait_idle();
        chk("R4 burst byte count", 32'(cap_n - cb), 32'(BL));
        for (int k = 0; k < BL; k++) begin
            chk("R5 R6 burst-from-zero address", 32'(cap_addr[cb + k]), {8'h0, 9'h1A5, 15'(k)});
            chk("R6 burst-from-zero data", 32'(cap_data[cb + k]), 32'(model[k]));
        end
        rd_reg(3'd3, v);
        chk("R4 burst bit cleared", v, 32'd0);

        // R5: second burst resumes after the previous one
        cb = cap_n;
        wr_reg(3'd3, 32'h1);
        wait_idle();
        chk("R5 resumed burst first address", 32'(cap_addr[cb]), {8'h0, 9'h1A5, 15'(BL)});
        chk("R5 resumed burst last address", 32'(cap_addr[cb + BL - 1]), {8'h0, 9'h1A5, 15'(2 * BL - 1)});

        // R2: random single reads
        for (int k = 0; k < 6; k++) begin
            a = 16'($urandom);
            b8 = model[a[9:0]];
            single_read(a, v);
            chk("R2 single read data", v, 32'(b8));
            rd_reg(3'd0, v);
            chk("R2 read bit cleared", v & 32'h3, 32'd0);
        end

        // R3: random single writes then read back
        for (int k = 0; k < 4; k++) begin
            a  = 16'($urandom);
            b8 = 8'($urandom);
            lb = log_n;
            wr_reg(3'd1, 32'(a));
            wr_reg(3'd2, 32'(b8));
            wr_reg(3'd0, 32'h1);
            wait_idle();
            chk("R3 write transfer count", 32'(log_n - lb), 32'd1);
            chk("R3 write address", 32'(log_addr[lb]), 32'(a));
            chk("R3 write flag", 32'(log_we[lb]), 32'd1);
            chk("R3 write byte", 32'(log_data[lb]), 32'(b8));
            wr_reg(3'd2, 32'h0);
            single_read(a, v);
            chk("R3 write read back", v, 32'(b8));
        end

        // R7: busy bit and writes locked during an access
        fixed_lat = 20;
        wr_reg(3'd1, 32'h0123);
        wr_reg(3'd0, 32'h2);
        rd_reg(3'd0, v);
        chk("R7 busy bit during access", 32'(v[2]), 32'd1);
        wr_reg(3'd1, 32'h0456);
        wr_reg(3'd4, 32'h0AA);
        wait_idle();
        fixed_lat = 0;
        rd_reg(3'd1, v);
        chk("R7 address write ignored while busy", v, 32'h0123);
        rd_reg(3'd4, v);
        chk("R7 base write ignored while busy", v, 32'h1A5);
        rd_reg(3'd2, v);
        chk("R7 read still completed", v, 32'(model[10'h123]));

        // R9 R5 R6: read, write and burst pending together; low field wraps
        wr_reg(3'd1, 32'h7FF0);
        wr_reg(3'd2, 32'h5C);
        lb = log_n;
        cb = cap_n;
        wr_two(3'd3, 32'h1, 3'd0, 32'h3);
        wait_idle();
        chk("R9 transfer count", 32'(log_n - lb), 32'(BL + 2));
        chk("R9 first is read", 32'(log_we[lb]), 32'd0);
        chk("R9 first address", 32'(log_addr[lb]), 32'h7FF0);
        chk("R9 second is write", 32'(log_we[lb + 1]), 32'd1);
        chk("R9 second address", 32'(log_addr[lb + 1]), 32'h7FF0);
        chk("R9 burst after single", 32'(log_addr[lb + 2]), 32'h7FF1);
        for (int k = 0; k < BL; k++) begin
            a = 16'(32'h7FF1 + k);
            chk("R5 burst eeprom address", 32'(log_addr[lb + 2 + k]), 32'(a));
            chk("R6 wrapped memory address", 32'(cap_addr[cb + k]), {8'h0, 9'h1A5, a[14:0]});
            chk("R6 wrapped memory data", 32'(cap_data[cb + k]), 32'(model[a[9:0]]));
        end

        // R8: timeout
        rd_reg(3'd2, v);
        b8 = v[7:0];
        mute = 1;
        wr_reg(3'd1, 32'h0200);
        wr_reg(3'd0, 32'h2);
        wait_idle();
        mute = 0;
        rd_reg(3'd0, v);
        chk("R8 timeout flag, request cleared", v, 32'h8);
        rd_reg(3'd2, v);
        chk("R8 data unchanged", v, 32'(b8));
        chk("R8 request length", 32'(last_run), 32'(TMO));
        single_read(16'h0201, v);
        chk("R8 later read works", v, 32'(model[10'h201]));
        rd_reg(3'd0, v);
        chk("R8 flag sticky", v, 32'h8);

        // R10: request stability seen at the port
        chk("R10 address stable while waiting", 32'(viol), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

endmodule